// File: doc/BRIEF.md
# Queued Command Tag Tracker

This block keeps the bookkeeping for one storage port that runs natively queued read and write commands. Each queued command arrives with an opcode and a tag byte. The tag number is held in the upper five bits of that byte. An accepted tag is marked busy in an in-use table and in the device-active vector. When the media side reports that a tag has finished, with success or failure, the block frees the tag. It then updates the port's error and status bytes, marks failures in a sticky error vector, and adds the tag to a finished-tags accumulator.

While frame reception is enabled, every completion produces a set-device-bits record and an interrupt pulse. The record holds the error byte, the masked status byte and the finished mask, and it is presented on an output port. A read of the device-active vector retires the accumulated finished bits from that vector and empties the accumulator. Media access and the memory writes of the record are handled by neighbouring logic.

Top module: `ncq_tag_tracker`

## Requirements
- R1: After `rst`, the in-use, active, error and finished vectors are zero, the record is zero, and `sdb_irq_o` and `iss_reject_o` are low.
- R2: An issue with opcode 0x60 (queued read) or 0x61 (queued write) uses tag = `iss_tagbyte_i[7:3]`, and the low three bits are ignored. If that tag is free and below NTAGS, its bit is set in `inuse_o` and in the active vector on the next clock edge.
- R3: A queued issue whose tag is already in use is dropped. `iss_reject_o` pulses for one cycle after the issue, and `inuse_o` and the active vector keep their values.
- R4: An issue with any other opcode changes no state and raises no reject.
- R5: A queued issue whose tag is NTAGS or above is dropped with a reject pulse.
- R6: A completion of an in-use tag clears its bits in `inuse_o` and in the active vector. On success the status becomes 0x50 (ready plus seek-complete), and the error byte keeps its previous value.
- R7: A failed completion sets the error byte to 0x04 (abort) and the status to 0x41 (ready plus error). It also sets the tag's bit in `serr_o`, which stays set until a reset.
- R8: With `fis_rx_en_i` high, a completion ORs the tag's bit into `finished_o`. One cycle later `sdb_irq_o` pulses, and `sdb_rec_o` holds byte 0 = error, byte 1 = 0, byte 2 = status AND 0x77, byte 3 = 0, and bytes 4 to 7 = the finished mask in little-endian order, with bit i standing for tag i.
- R9: `act_rdata_o` reads as active AND NOT finished. While `act_rd_i` is high, the next edge removes the finished bits from the active vector and empties the accumulator. A completion in that same cycle stays in the fresh accumulator.
- R10: A completion for a tag that is not in use is ignored.
- R11: With `fis_rx_en_i` low, a completion frees the tag and updates the error, status and `serr_o`. It raises no interrupt, leaves the record unchanged and does not add to the accumulator.
- R12: `port_rst_i` clears every vector, the error and status bytes and the record on the next edge. It overrides any issue, completion or read in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| port_rst_i | input | 1 | Port reset, frees all tags |
| fis_rx_en_i | input | 1 | Frame reception enabled |
| iss_valid_i | input | 1 | Queued command issue strobe |
| iss_opcode_i | input | 8 | Command opcode |
| iss_tagbyte_i | input | 8 | Tag byte, tag in bits 7:3 |
| cpl_valid_i | input | 1 | Completion strobe |
| cpl_tag_i | input | TAG_W | Completed tag |
| cpl_fail_i | input | 1 | Completion failed |
| act_rd_i | input | 1 | Read of the active vector |
| act_rdata_o | output | NTAGS | Active vector read data |
| inuse_o | output | NTAGS | Tags in use |
| serr_o | output | NTAGS | Sticky per-tag error bits |
| finished_o | output | NTAGS | Finished-tags accumulator |
| iss_reject_o | output | 1 | Dropped issue pulse |
| sdb_irq_o | output | 1 | Set-device-bits interrupt pulse |
| sdb_rec_o | output | 64 | Set-device-bits record |

## Verification
The bench builds the block with NTAGS = 8, so TAG_W = 3. The tag byte still carries five tag bits, which lets the bench issue tags 8 and above and reach the out-of-range drop. It also fills the whole table in a few cycles and then issues once more into the full table. With eight tags, the finished mask sits in the low byte of the record's upper word, and the bench checks that the padding above it stays zero.

// File: rtl/ncq_pkg.sv
package ncq_pkg;

    localparam logic [7:0] OPC_Q_READ  = 8'h60;
    localparam logic [7:0] OPC_Q_WRITE = 8'h61;

    localparam logic [7:0] ST_READY    = 8'h40;
    localparam logic [7:0] ST_SEEK     = 8'h10;
    localparam logic [7:0] ST_ERROR    = 8'h01;
    localparam logic [7:0] ST_MASK     = 8'h77;
    localparam logic [7:0] ERR_ABORT   = 8'h04;

    localparam int RAW_TAG_W = 5;
    localparam int REC_W     = 64;

    // Set-device-bits record, byte 0 in the least significant position
    typedef struct packed {
        logic [31:0] fin_mask;
        logic [7:0]  pad_hi;
        logic [7:0]  stat;
        logic [7:0]  pad_lo;
        logic [7:0]  err;
    } sdb_rec_t;

    typedef struct packed {
        logic [7:0] err;
        logic [7:0] stat;
    } port_regs_t;

    function automatic logic is_queued_opc(input logic [7:0] opc);
        return (opc == OPC_Q_READ) || (opc == OPC_Q_WRITE);
    endfunction

    function automatic logic [RAW_TAG_W-1:0] tag_of(input logic [7:0] tb);
        return tb[7:3];
    endfunction

endpackage

// File: rtl/ncq_issue_gate.sv
module ncq_issue_gate
    import ncq_pkg::*;
#(
    parameter int NTAGS = 32,
    parameter int TAG_W = $clog2(NTAGS)
) (
    input  logic             iss_valid_i,
    input  logic [7:0]       iss_opcode_i,
    input  logic [7:0]       iss_tagbyte_i,
    input  logic [NTAGS-1:0] inuse_i,
    output logic             accept_o,
    output logic             reject_o,
    output logic [TAG_W-1:0] tag_o
);

    logic [RAW_TAG_W-1:0] raw_tag;
    logic                 queued;
    logic                 in_range;
    logic                 busy;

    always_comb begin
        raw_tag  = tag_of(iss_tagbyte_i);
        queued   = is_queued_opc(iss_opcode_i);
        in_range = int'(raw_tag) < NTAGS;
        tag_o    = raw_tag[TAG_W-1:0];
        busy     = 1'b0;
        if (in_range) begin
            busy = inuse_i[tag_o];
        end
        accept_o = iss_valid_i && queued && in_range && !busy;
        reject_o = iss_valid_i && queued && (!in_range || busy);
    end

endmodule

// File: rtl/ncq_tag_state.sv
module ncq_tag_state
    import ncq_pkg::*;
#(
    parameter int NTAGS = 32,
    parameter int TAG_W = $clog2(NTAGS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             port_rst_i,
    input  logic             fis_rx_en_i,
    input  logic             acc_i,
    input  logic             rej_i,
    input  logic [TAG_W-1:0] acc_tag_i,
    input  logic             cpl_valid_i,
    input  logic [TAG_W-1:0] cpl_tag_i,
    input  logic             cpl_fail_i,
    input  logic             act_rd_i,
    output logic [NTAGS-1:0] inuse_o,
    output logic [NTAGS-1:0] active_o,
    output logic [NTAGS-1:0] serr_o,
    output logic [NTAGS-1:0] fin_o,
    output logic             reject_o,
    output logic             sdb_evt_o,
    output port_regs_t       regs_nx_o,
    output logic [NTAGS-1:0] fin_nx_o
);

    logic [NTAGS-1:0] inuse_q, active_q, serr_q, fin_q;
    logic [NTAGS-1:0] inuse_d, active_d, serr_d, fin_d;
    port_regs_t       regs_q, regs_d;
    logic             reject_q;
    logic             cpl_hit;
    logic             clear_all;

    assign clear_all = rst || port_rst_i;

    always_comb begin
        cpl_hit = 1'b0;
        if (cpl_valid_i && (int'(cpl_tag_i) < NTAGS)) begin
            cpl_hit = inuse_q[cpl_tag_i];
        end
    end

    always_comb begin
        regs_d = regs_q;
        if (cpl_hit) begin
            if (cpl_fail_i) begin
                regs_d.err  = ERR_ABORT;
                regs_d.stat = ST_READY | ST_ERROR;
            end else begin
                regs_d.stat = ST_READY | ST_SEEK;
            end
        end
    end

    for (genvar i = 0; i < NTAGS; i++) begin : g_tag
        logic set_i, done_i, retire_i;
        assign set_i    = acc_i && (acc_tag_i == TAG_W'(i));
        assign done_i   = cpl_hit && (cpl_tag_i == TAG_W'(i));
        assign retire_i = act_rd_i && fin_q[i];

        assign inuse_d[i]  = set_i | (inuse_q[i] & ~done_i);
        assign active_d[i] = set_i | (active_q[i] & ~done_i & ~retire_i);
        assign serr_d[i]   = serr_q[i] | (done_i & cpl_fail_i);
        assign fin_d[i]    = (fin_q[i] & ~act_rd_i) | (done_i & fis_rx_en_i);
    end

    always_ff @(posedge clk) begin
        if (clear_all) begin
            inuse_q  <= '0;
            active_q <= '0;
            serr_q   <= '0;
            fin_q    <= '0;
            regs_q   <= '0;
            reject_q <= 1'b0;
        end else begin
            inuse_q  <= inuse_d;
            active_q <= active_d;
            serr_q   <= serr_d;
            fin_q    <= fin_d;
            regs_q   <= regs_d;
            reject_q <= rej_i;
        end
    end

    assign inuse_o   = inuse_q;
    assign active_o  = active_q;
    assign serr_o    = serr_q;
    assign fin_o     = fin_q;
    assign reject_o  = reject_q;
    assign sdb_evt_o = cpl_hit && fis_rx_en_i && !port_rst_i;
    assign regs_nx_o = regs_d;
    assign fin_nx_o  = fin_d;

endmodule

// File: rtl/ncq_sdb_fmt.sv
module ncq_sdb_fmt
    import ncq_pkg::*;
#(
    parameter int NTAGS = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             port_rst_i,
    input  logic             evt_i,
    input  port_regs_t       regs_i,
    input  logic [NTAGS-1:0] fin_i,
    output logic             irq_o,
    output logic [REC_W-1:0] rec_o
);

    sdb_rec_t rec_q, rec_d;
    logic     irq_q;

    always_comb begin
        rec_d          = '0;
        rec_d.err      = regs_i.err;
        rec_d.stat     = regs_i.stat & ST_MASK;
        rec_d.fin_mask = 32'(fin_i);
    end

    always_ff @(posedge clk) begin
        if (rst || port_rst_i) begin
            rec_q <= '0;
            irq_q <= 1'b0;
        end else begin
            irq_q <= evt_i;
            if (evt_i) begin
                rec_q <= rec_d;
            end
        end
    end

    assign irq_o = irq_q;
    assign rec_o = rec_q;

endmodule

// File: rtl/ncq_tag_tracker.sv
module ncq_tag_tracker
    import ncq_pkg::*;
#(
    parameter int NTAGS = 32,
    parameter int TAG_W = $clog2(NTAGS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             port_rst_i,
    input  logic             fis_rx_en_i,
    input  logic             iss_valid_i,
    input  logic [7:0]       iss_opcode_i,
    input  logic [7:0]       iss_tagbyte_i,
    input  logic             cpl_valid_i,
    input  logic [TAG_W-1:0] cpl_tag_i,
    input  logic             cpl_fail_i,
    input  logic             act_rd_i,
    output logic [NTAGS-1:0] act_rdata_o,
    output logic [NTAGS-1:0] inuse_o,
    output logic [NTAGS-1:0] serr_o,
    output logic [NTAGS-1:0] finished_o,
    output logic             iss_reject_o,
    output logic             sdb_irq_o,
    output logic [63:0]      sdb_rec_o
);

    logic             acc, rej;
    logic [TAG_W-1:0] acc_tag;
    logic [NTAGS-1:0] active, fin_nx;
    logic             sdb_evt;
    port_regs_t       regs_nx;

    ncq_issue_gate #(.NTAGS(NTAGS), .TAG_W(TAG_W)) u_gate (
        .iss_valid_i   (iss_valid_i && !port_rst_i),
        .iss_opcode_i  (iss_opcode_i),
        .iss_tagbyte_i (iss_tagbyte_i),
        .inuse_i       (inuse_o),
        .accept_o      (acc),
        .reject_o      (rej),
        .tag_o         (acc_tag)
    );

    ncq_tag_state #(.NTAGS(NTAGS), .TAG_W(TAG_W)) u_state (
        .clk         (clk),
        .rst         (rst),
        .port_rst_i  (port_rst_i),
        .fis_rx_en_i (fis_rx_en_i),
        .acc_i       (acc),
        .rej_i       (rej),
        .acc_tag_i   (acc_tag),
        .cpl_valid_i (cpl_valid_i),
        .cpl_tag_i   (cpl_tag_i),
        .cpl_fail_i  (cpl_fail_i),
        .act_rd_i    (act_rd_i),
        .inuse_o     (inuse_o),
        .active_o    (active),
        .serr_o      (serr_o),
        .fin_o       (finished_o),
        .reject_o    (iss_reject_o),
        .sdb_evt_o   (sdb_evt),
        .regs_nx_o   (regs_nx),
        .fin_nx_o    (fin_nx)
    );

    ncq_sdb_fmt #(.NTAGS(NTAGS)) u_fmt (
        .clk        (clk),
        .rst        (rst),
        .port_rst_i (port_rst_i),
        .evt_i      (sdb_evt),
        .regs_i     (regs_nx),
        .fin_i      (fin_nx),
        .irq_o      (sdb_irq_o),
        .rec_o      (sdb_rec_o)
    );

    assign act_rdata_o = active & ~finished_o;

endmodule

// File: rtl/ncq_tag_tracker_chk.sv
module ncq_tag_tracker_chk #(
    parameter int NTAGS = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             port_rst_i,
    input logic             fis_rx_en_i,
    input logic             cpl_valid_i,
    input logic             act_rd_i,
    input logic [NTAGS-1:0] act_rdata_o,
    input logic [NTAGS-1:0] inuse_o,
    input logic [NTAGS-1:0] serr_o,
    input logic [NTAGS-1:0] finished_o,
    input logic             iss_reject_o,
    input logic             sdb_irq_o,
    input logic [63:0]      sdb_rec_o
);

    p_irq_cause_r8: assert property (@(posedge clk) disable iff (rst)
        sdb_irq_o |-> ($past(cpl_valid_i) && $past(fis_rx_en_i) && !$past(port_rst_i)));

    p_rec_layout_r8: assert property (@(posedge clk) disable iff (rst)
        sdb_irq_o |-> (((sdb_rec_o[23:16] & 8'h88) == 8'h00) && (sdb_rec_o[15:8] == 8'h00)
                       && (sdb_rec_o[31:24] == 8'h00) && ($countones(sdb_rec_o[63:32]) != 0)));

    p_port_clear_r12: assert property (@(posedge clk) disable iff (rst)
        port_rst_i |=> ((inuse_o == '0) && (act_rdata_o == '0) && (serr_o == '0)
                        && (finished_o == '0) && !sdb_irq_o && !iss_reject_o && (sdb_rec_o == '0)));

    p_serr_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        !port_rst_i |=> ((serr_o & $past(serr_o)) == $past(serr_o)));

    p_read_empties_r9: assert property (@(posedge clk) disable iff (rst)
        (act_rd_i && !cpl_valid_i && !port_rst_i) |=> (finished_o == '0));

    p_reject_keeps_r3: assert property (@(posedge clk) disable iff (rst)
        (iss_reject_o && !$past(cpl_valid_i)) |-> $stable(inuse_o));

endmodule

bind ncq_tag_tracker ncq_tag_tracker_chk #(.NTAGS(NTAGS)) chk_i (
    .clk          (clk),
    .rst          (rst),
    .port_rst_i   (port_rst_i),
    .fis_rx_en_i  (fis_rx_en_i),
    .cpl_valid_i  (cpl_valid_i),
    .act_rd_i     (act_rd_i),
    .act_rdata_o  (act_rdata_o),
    .inuse_o      (inuse_o),
    .serr_o       (serr_o),
    .finished_o   (finished_o),
    .iss_reject_o (iss_reject_o),
    .sdb_irq_o    (sdb_irq_o),
    .sdb_rec_o    (sdb_rec_o)
);

// File: tb/ncq_tag_tracker_tb.sv
module ncq_tag_tracker_tb_top;

    localparam int NT = 8;
    localparam int TW = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          port_rst_i = 1'b0;
    logic          fis_rx_en_i = 1'b1;
    logic          iss_valid_i = 1'b0;
    logic [7:0]    iss_opcode_i = '0;
    logic [7:0]    iss_tagbyte_i = '0;
    logic          cpl_valid_i = 1'b0;
    logic [TW-1:0] cpl_tag_i = '0;
    logic          cpl_fail_i = 1'b0;
    logic          act_rd_i = 1'b0;
    logic [NT-1:0] act_rdata_o, inuse_o, serr_o, finished_o;
    logic          iss_reject_o, sdb_irq_o;
    logic [63:0]   sdb_rec_o;

    int total = 0;
    int bad = 0;
    logic [63:0] expq[$];

    always #10 clk = ~clk;

    ncq_tag_tracker #(.NTAGS(NT)) dut_i (
        .clk (clk), .rst (rst), .port_rst_i (port_rst_i), .fis_rx_en_i (fis_rx_en_i),
        .iss_valid_i (iss_valid_i), .iss_opcode_i (iss_opcode_i), .iss_tagbyte_i (iss_tagbyte_i),
        .cpl_valid_i (cpl_valid_i), .cpl_tag_i (cpl_tag_i), .cpl_fail_i (cpl_fail_i),
        .act_rd_i (act_rd_i), .act_rdata_o (act_rdata_o), .inuse_o (inuse_o),
        .serr_o (serr_o), .finished_o (finished_o), .iss_reject_o (iss_reject_o),
        .sdb_irq_o (sdb_irq_o), .sdb_rec_o (sdb_rec_o)
    );

    function automatic logic [63:0] rec(input logic [7:0] e, input logic [7:0] s, input logic [31:0] f);
        return {f, 8'h00, s, 8'h00, e};
    endfunction

    task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    // Monitor: every interrupt pops one expected record
    always @(negedge clk) begin
        if (!rst && sdb_irq_o) begin
            if (expq.size() == 0) begin
                chk("R8/R10/R11 unexpected irq", sdb_rec_o, 64'h0);
                if (sdb_rec_o == 64'h0) begin
                    bad++;
                    $display("FAIL R8 unexpected irq actual=1 expected=0");
                end
            end else begin
                chk("R8 record", sdb_rec_o, expq.pop_front());
            end
        end
    end

    task automatic issue(input logic [7:0] op, input logic [7:0] tb);
        @(negedge clk);
        iss_valid_i = 1'b1; iss_opcode_i = op; iss_tagbyte_i = tb;
        @(negedge clk);
        iss_valid_i = 1'b0;
    endtask

    task automatic cpl(input int tag, input logic fail, input logic fis);
        @(negedge clk);
        cpl_valid_i = 1'b1; cpl_tag_i = TW'(tag); cpl_fail_i = fail; fis_rx_en_i = fis;
        @(negedge clk);
        cpl_valid_i = 1'b0; fis_rx_en_i = 1'b1;
    endtask

    initial begin
        #(20 * 100000);
        bad++; total++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 inuse", 64'(inuse_o), 0);
        chk("R1 active", 64'(act_rdata_o), 0);
        chk("R1 serr/fin", {serr_o, finished_o}, 0);
        chk("R1 pulses/rec", {iss_reject_o, sdb_irq_o, sdb_rec_o}, 0);

        // R2 accepts
        issue(8'h60, 8'h18);
        chk("R2 read tag3 inuse", 64'(inuse_o), 64'h08);
        chk("R2 read tag3 active", 64'(act_rdata_o), 64'h08);
        issue(8'h61, 8'h2F);
        chk("R2 write tag5 low bits ignored", 64'(inuse_o), 64'h28);

        // R3 duplicate
        issue(8'h60, 8'h1C);
        chk("R3 reject pulse", 64'(iss_reject_o), 1);
        chk("R3 inuse kept", 64'(inuse_o), 64'h28);

        // R4 other opcode
        issue(8'h25, 8'h08);
        chk("R4 no reject", 64'(iss_reject_o), 0);
        chk("R4 inuse kept", 64'(inuse_o), 64'h28);
        chk("R4 active kept", 64'(act_rdata_o), 64'h28);

        // R5 out of range tag 8
        issue(8'h60, 8'h40);
        chk("R5 reject pulse", 64'(iss_reject_o), 1);
        chk("R5 inuse kept", 64'(inuse_o), 64'h28);

        // R6 success on tag 3
        expq.push_back(rec(8'h00, 8'h50, 32'h08));
        cpl(3, 1'b0, 1'b1);
        chk("R6 inuse freed", 64'(inuse_o), 64'h20);
        chk("R6 active cleared", 64'(act_rdata_o), 64'h20);
        chk("R8 accumulator", 64'(finished_o), 64'h08);

        // R7 failure on tag 5
        expq.push_back(rec(8'h04, 8'h41, 32'h28));
        cpl(5, 1'b1, 1'b1);
        chk("R7 serr", 64'(serr_o), 64'h20);
        chk("R8 accumulator grows", 64'(finished_o), 64'h28);

        // R9 reissue tag 3 then read the active vector
        issue(8'h60, 8'h18);
        chk("R9 read data masks finished", 64'(act_rdata_o), 64'h00);
        @(negedge clk);
        act_rd_i = 1'b1;
        #1 chk("R9 read data", 64'(act_rdata_o), 64'h00);
        @(negedge clk);
        act_rd_i = 1'b0;
        chk("R9 accumulator emptied", 64'(finished_o), 64'h00);
        chk("R9 tag3 still in use", 64'(inuse_o), 64'h08);
        chk("R9 active retired", 64'(act_rdata_o), 64'h00);

        // R10 completion of unused tag 6
        cpl(6, 1'b1, 1'b1);
        chk("R10 serr unchanged", 64'(serr_o), 64'h20);
        chk("R10 state unchanged", {inuse_o, finished_o}, {8'h08, 8'h00});

        // R6 error byte held across success
        expq.push_back(rec(8'h04, 8'h50, 32'h08));
        cpl(3, 1'b0, 1'b1);
        chk("R6 tag3 freed", 64'(inuse_o), 64'h00);

        // R11 reception disabled
        issue(8'h60, 8'h10);
        cpl(2, 1'b1, 1'b0);
        chk("R11 tag freed", 64'(inuse_o), 64'h00);
        chk("R11 serr set", 64'(serr_o), 64'h24);
        chk("R11 accumulator unchanged", 64'(finished_o), 64'h08);
        chk("R11 record held", sdb_rec_o, rec(8'h04, 8'h50, 32'h08));
        issue(8'h61, 8'h20);
        expq.push_back(rec(8'h04, 8'h50, 32'h18));
        cpl(4, 1'b0, 1'b1);

        // R9 read and completion in the same cycle
        issue(8'h60, 8'h38);
        expq.push_back(rec(8'h04, 8'h50, 32'h80));
        @(negedge clk);
        act_rd_i = 1'b1; cpl_valid_i = 1'b1; cpl_tag_i = 3'd7; cpl_fail_i = 1'b0;
        @(negedge clk);
        act_rd_i = 1'b0; cpl_valid_i = 1'b0;
        chk("R9 same-cycle completion kept", 64'(finished_o), 64'h80);

        // R2/R3 full table
        for (int i = 0; i < NT; i++) issue(8'h61, 8'(i << 3));
        chk("R2 full table", 64'(inuse_o), 64'hFF);
        issue(8'h60, 8'h00);
        chk("R3 full table reject", 64'(iss_reject_o), 1);

        // R12 port reset with a same-cycle completion
        @(negedge clk);
        port_rst_i = 1'b1; cpl_valid_i = 1'b1; cpl_tag_i = 3'd1; cpl_fail_i = 1'b1;
        @(negedge clk);
        port_rst_i = 1'b0; cpl_valid_i = 1'b0;
        chk("R12 vectors cleared", {inuse_o, serr_o, finished_o, act_rdata_o}, 0);
        chk("R12 record cleared", {sdb_irq_o, sdb_rec_o}, 0);
        issue(8'h60, 8'h10);
        chk("R12 accepts after reset", 64'(inuse_o), 64'h04);

        repeat (2) @(negedge clk);
        chk("R8 all records seen", 64'(expq.size()), 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule